// File: doc/BRIEF.md
# Register-Range Vector Issue Sequencer

This block turns one scalar-style instruction into a run of element micro-ops over consecutive architectural registers. Each register in the integer file and in the floating-point file has its own configuration entry holding a vector length and an element-width code. The length belongs to the register, not to the instruction. A destination or source whose length is L > 1 stands for L registers starting at its base index. A length of 1 marks a plain scalar.

An accepted instruction names a register file, a destination, two sources and an operation class, and it carries a predicate word. The sequencer reads the three configuration entries through a single read port, one per cycle. It then checks that every range is legal and emits one micro-op per cycle under a valid/ready handshake. A scalar source mixed with vector operands is reused for every element. A scalar destination with a vector source turns the run into a sequential reduction. Elements whose predicate bit is clear are still emitted, but with their enable low, so the destination element keeps its old value.

Top module: `vis_issue_seq`

## Requirements
- R1: After reset every configuration entry in both files holds length 1 and width code 0. The block shows in_ready_o=1, uop_valid_o=0 and err_o=0. An instruction on unconfigured registers yields exactly one micro-op, with uop_last_o=1 and uop_red_o=0.
- R2: A configuration write stores the length and width code for the register chosen by cfg_fp_i (0 = integer file, 1 = floating-point file) and cfg_idx_i. in_fp_i selects which file is consulted for an instruction. uop_ew_o carries the destination's width code.
- R3: With a destination of length L > 1, exactly L micro-ops are emitted. Element i (counting from 0) has destination index rd+i, and index base+i for each vector source. uop_last_o is 1 only on element L-1.
- R4: A source of length 1 keeps its base index on every element of the run.
- R5: uop_en_o of element i equals bit i of the predicate word sampled when the instruction is accepted. Elements with a clear bit are still emitted.
- R6: With a destination of length 1, the element count is the largest source length. When that count exceeds 1, every micro-op carries the same destination index and has uop_red_o=1.
- R7: The instruction is illegal if any of the following holds: an operand has length 0; an operand's range base+length exceeds the register count; or an operand with length above 1 differs from the element count. An illegal instruction gives a one-cycle err_o pulse, emits no micro-op, and frees the input.
- R8: Registers keep their lengths independently, so back-to-back instructions on differently configured bases each use their own lengths with no write in between.
- R9: The first micro-op, or err_o, appears on the third rising edge after the accepting edge. Further micro-ops follow one per cycle while uop_ready_i is high. While uop_ready_i is low, the presented micro-op is held unchanged.
- R10: in_ready_o is low from acceptance until the handshake of the last micro-op or the error pulse, and high on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_fp_i | input | 1 | register file of the write (1 = floating point) |
| cfg_idx_i | input | IW | register index of the write |
| cfg_vl_i | input | VL_W | vector length to store |
| cfg_ew_i | input | EW_W | element-width code to store |
| in_valid_i | input | 1 | instruction valid |
| in_ready_o | output | 1 | sequencer idle and able to accept |
| in_op_i | input | OP_W | operation class, passed through |
| in_fp_i | input | 1 | register file for length lookup |
| in_rd_i | input | IW | destination base index |
| in_rs1_i | input | IW | first source base index |
| in_rs2_i | input | IW | second source base index |
| in_pred_i | input | NREG | predicate word, bit i for element i |
| uop_valid_o | output | 1 | micro-op valid |
| uop_ready_i | input | 1 | micro-op accepted by downstream |
| uop_op_o | output | OP_W | operation class |
| uop_fp_o | output | 1 | register file |
| uop_rd_o | output | IW | destination index of this element |
| uop_rs1_o | output | IW | first source index of this element |
| uop_rs2_o | output | IW | second source index of this element |
| uop_ew_o | output | EW_W | element-width code of the destination |
| uop_en_o | output | 1 | element enable from the predicate |
| uop_last_o | output | 1 | final element of the run |
| uop_red_o | output | 1 | element belongs to a reduction |
| err_o | output | 1 | one-cycle illegal-configuration pulse |

## Verification
Three register stages separate acceptance from the first result: the destination lookup, the first-source lookup, and the legality decision made with the second-source lookup. The first micro-op or the error pulse is therefore due three rising edges after the accepting edge. Each further element is due one edge after the previous handshake. The bench drives and samples only on falling edges, counts falling edges from acceptance to the first result, and requires that count to be exactly four. It then checks one element per falling edge, and during a deliberate stall it checks that the held micro-op does not move.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int VL_W = 8;
  localparam int EW_W = 2;
  localparam int OP_W = 4;

  typedef struct packed {
    logic [EW_W-1:0] ew;
    logic [VL_W-1:0] vl;
  } reg_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LK_D, ST_LK_A, ST_LK_B, ST_ISSUE
  } seq_st_e;
endpackage

// File: rtl/vis_cfg_table.sv
module vis_cfg_table
  import vis_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG),
  localparam int DEPTH = 2 * NREG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_fp_i,
  input  logic [IW-1:0] wr_idx_i,
  input  reg_cfg_t      wr_val_i,
  input  logic          rd_fp_i,
  input  logic [IW-1:0] rd_idx_i,
  output reg_cfg_t      rd_val_o
);
  // one write port, one read port; file bit is the address MSB (NREG power of 2)
  reg_cfg_t tab_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) tab_q[k] <= '{ew: '0, vl: VL_W'(1)};
    end else if (wr_en_i) begin
      tab_q[{wr_fp_i, wr_idx_i}] <= wr_val_i;
    end
  end

  assign rd_val_o = tab_q[{rd_fp_i, rd_idx_i}];
endmodule

// File: rtl/vis_range_chk.sv
module vis_range_chk
  import vis_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG),
  localparam int SW = ((VL_W > IW) ? VL_W : IW) + 1
) (
  input  logic [VL_W-1:0] vl_d_i,
  input  logic [VL_W-1:0] vl_a_i,
  input  logic [VL_W-1:0] vl_b_i,
  input  logic [IW-1:0]   base_d_i,
  input  logic [IW-1:0]   base_a_i,
  input  logic [IW-1:0]   base_b_i,
  output logic [VL_W-1:0] cnt_o,
  output logic            bad_o
);
  logic [2:0][VL_W-1:0] vl;
  logic [2:0][IW-1:0]   base;

  assign vl   = {vl_b_i, vl_a_i, vl_d_i};
  assign base = {base_b_i, base_a_i, base_d_i};

  always_comb begin
    // element count: destination length, else longest source
    if (vl_d_i != VL_W'(1)) cnt_o = vl_d_i;
    else                    cnt_o = (vl_a_i > vl_b_i) ? vl_a_i : vl_b_i;
    bad_o = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (vl[k] == '0) bad_o = 1'b1;
      if (vl[k] != VL_W'(1) && vl[k] != cnt_o) bad_o = 1'b1;
      if (SW'(vl[k]) + SW'(base[k]) > SW'(NREG)) bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/vis_seq.sv
module vis_seq
  import vis_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [OP_W-1:0] in_op_i,
  input  logic            in_fp_i,
  input  logic [IW-1:0]   in_rd_i,
  input  logic [IW-1:0]   in_rs1_i,
  input  logic [IW-1:0]   in_rs2_i,
  input  logic [NREG-1:0] in_pred_i,
  output logic            tab_fp_o,
  output logic [IW-1:0]   tab_idx_o,
  input  reg_cfg_t        tab_val_i,
  output logic            uop_valid_o,
  input  logic            uop_ready_i,
  output logic [OP_W-1:0] uop_op_o,
  output logic            uop_fp_o,
  output logic [IW-1:0]   uop_rd_o,
  output logic [IW-1:0]   uop_rs1_o,
  output logic [IW-1:0]   uop_rs2_o,
  output logic [EW_W-1:0] uop_ew_o,
  output logic            uop_en_o,
  output logic            uop_last_o,
  output logic            uop_red_o,
  output logic            err_o
);
  seq_st_e         st_q;
  logic [OP_W-1:0] op_q;
  logic            fp_q;
  logic [IW-1:0]   rd_q, ra_q, rb_q;
  logic [NREG-1:0] pred_q;
  reg_cfg_t        dst_q;
  logic [VL_W-1:0] vla_q, cnt_q;
  logic            dv_q, av_q, bv_q, red_q, err_q;
  logic [IW-1:0]   el_q;
  logic [VL_W-1:0] cnt;
  logic            bad, last;

  vis_range_chk #(.NREG(NREG)) u_rchk (
    .vl_d_i  (dst_q.vl),
    .vl_a_i  (vla_q),
    .vl_b_i  (tab_val_i.vl),
    .base_d_i(rd_q),
    .base_a_i(ra_q),
    .base_b_i(rb_q),
    .cnt_o   (cnt),
    .bad_o   (bad)
  );

  // single read port walks rd, rs1, rs2 over three cycles
  always_comb begin
    tab_fp_o = fp_q;
    unique case (st_q)
      ST_LK_A: tab_idx_o = ra_q;
      ST_LK_B: tab_idx_o = rb_q;
      default: tab_idx_o = rd_q;
    endcase
  end

  assign last = (VL_W'(el_q) == cnt_q - VL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      fp_q   <= 1'b0;
      rd_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      pred_q <= '0;
      dst_q  <= '0;
      vla_q  <= '0;
      cnt_q  <= '0;
      dv_q   <= 1'b0;
      av_q   <= 1'b0;
      bv_q   <= 1'b0;
      red_q  <= 1'b0;
      err_q  <= 1'b0;
      el_q   <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (in_valid_i) begin
          op_q   <= in_op_i;
          fp_q   <= in_fp_i;
          rd_q   <= in_rd_i;
          ra_q   <= in_rs1_i;
          rb_q   <= in_rs2_i;
          pred_q <= in_pred_i;
          st_q   <= ST_LK_D;
        end
        ST_LK_D: begin
          dst_q <= tab_val_i;
          st_q  <= ST_LK_A;
        end
        ST_LK_A: begin
          vla_q <= tab_val_i.vl;
          st_q  <= ST_LK_B;
        end
        ST_LK_B: begin
          cnt_q <= cnt;
          dv_q  <= (dst_q.vl != VL_W'(1));
          av_q  <= (vla_q != VL_W'(1));
          bv_q  <= (tab_val_i.vl != VL_W'(1));
          red_q <= (dst_q.vl == VL_W'(1)) && (cnt != VL_W'(1));
          el_q  <= '0;
          if (bad) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (uop_ready_i) begin
          if (last) st_q <= ST_IDLE;
          else      el_q <= el_q + IW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (st_q == ST_IDLE);
  assign uop_valid_o = (st_q == ST_ISSUE);
  assign uop_op_o    = op_q;
  assign uop_fp_o    = fp_q;
  assign uop_rd_o    = rd_q + (dv_q ? el_q : '0);
  assign uop_rs1_o   = ra_q + (av_q ? el_q : '0);
  assign uop_rs2_o   = rb_q + (bv_q ? el_q : '0);
  assign uop_ew_o    = dst_q.ew;
  assign uop_en_o    = pred_q[el_q];
  assign uop_last_o  = last;
  assign uop_red_o   = red_q;
  assign err_o       = err_q;
endmodule

// File: rtl/vis_issue_seq.sv
module vis_issue_seq
  import vis_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            cfg_fp_i,
  input  logic [IW-1:0]   cfg_idx_i,
  input  logic [VL_W-1:0] cfg_vl_i,
  input  logic [EW_W-1:0] cfg_ew_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [OP_W-1:0] in_op_i,
  input  logic            in_fp_i,
  input  logic [IW-1:0]   in_rd_i,
  input  logic [IW-1:0]   in_rs1_i,
  input  logic [IW-1:0]   in_rs2_i,
  input  logic [NREG-1:0] in_pred_i,
  output logic            uop_valid_o,
  input  logic            uop_ready_i,
  output logic [OP_W-1:0] uop_op_o,
  output logic            uop_fp_o,
  output logic [IW-1:0]   uop_rd_o,
  output logic [IW-1:0]   uop_rs1_o,
  output logic [IW-1:0]   uop_rs2_o,
  output logic [EW_W-1:0] uop_ew_o,
  output logic            uop_en_o,
  output logic            uop_last_o,
  output logic            uop_red_o,
  output logic            err_o
);
  logic          tab_fp;
  logic [IW-1:0] tab_idx;
  reg_cfg_t      tab_val;
  reg_cfg_t      wr_val;

  assign wr_val = '{ew: cfg_ew_i, vl: cfg_vl_i};

  vis_cfg_table #(.NREG(NREG)) u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_we_i),
    .wr_fp_i (cfg_fp_i),
    .wr_idx_i(cfg_idx_i),
    .wr_val_i(wr_val),
    .rd_fp_i (tab_fp),
    .rd_idx_i(tab_idx),
    .rd_val_o(tab_val)
  );

  vis_seq #(.NREG(NREG)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_op_i    (in_op_i),
    .in_fp_i    (in_fp_i),
    .in_rd_i    (in_rd_i),
    .in_rs1_i   (in_rs1_i),
    .in_rs2_i   (in_rs2_i),
    .in_pred_i  (in_pred_i),
    .tab_fp_o   (tab_fp),
    .tab_idx_o  (tab_idx),
    .tab_val_i  (tab_val),
    .uop_valid_o(uop_valid_o),
    .uop_ready_i(uop_ready_i),
    .uop_op_o   (uop_op_o),
    .uop_fp_o   (uop_fp_o),
    .uop_rd_o   (uop_rd_o),
    .uop_rs1_o  (uop_rs1_o),
    .uop_rs2_o  (uop_rs2_o),
    .uop_ew_o   (uop_ew_o),
    .uop_en_o   (uop_en_o),
    .uop_last_o (uop_last_o),
    .uop_red_o  (uop_red_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/vis_issue_chk.sv
module vis_issue_chk #(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          uop_valid_o,
  input logic          uop_ready_i,
  input logic [IW-1:0] uop_rd_o,
  input logic [IW-1:0] uop_rs1_o,
  input logic [IW-1:0] uop_rs2_o,
  input logic          uop_en_o,
  input logic          uop_last_o,
  input logic          uop_red_o,
  input logic          err_o
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_rd_o) && $stable(uop_rs1_o)
      && $stable(uop_rs2_o) && $stable(uop_en_o) && $stable(uop_last_o));

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> !in_ready_o);

  assert_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_last_o |=> in_ready_o && !uop_valid_o);

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o && !uop_red_o |=>
      uop_valid_o && uop_rd_o == IW'($past(uop_rd_o) + 1'b1));

  assert_accum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o && uop_red_o |=>
      uop_valid_o && uop_red_o && uop_rd_o == $past(uop_rd_o));

  assert_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !uop_valid_o && in_ready_o);

  assert_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !uop_valid_o && !err_o && !in_ready_o);
endmodule

bind vis_issue_seq vis_issue_chk #(.NREG(NREG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .uop_valid_o(uop_valid_o),
  .uop_ready_i(uop_ready_i),
  .uop_rd_o   (uop_rd_o),
  .uop_rs1_o  (uop_rs1_o),
  .uop_rs2_o  (uop_rs2_o),
  .uop_en_o   (uop_en_o),
  .uop_last_o (uop_last_o),
  .uop_red_o  (uop_red_o),
  .err_o      (err_o)
);

// File: tb/sim_vis_issue_seq.sv
module sim_vis_issue_seq;
  import vis_pkg::*;
  localparam int NREG = 32;
  localparam int IW = $clog2(NREG);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_fp = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [VL_W-1:0] cfg_vl = '0;
  logic [EW_W-1:0] cfg_ew = '0;
  logic in_valid = 0, in_fp = 0;
  logic [OP_W-1:0] in_op = '0;
  logic [IW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [NREG-1:0] in_pred = '0;
  logic uop_ready = 1'b1;
  logic in_ready, uop_valid, uop_fp, uop_en, uop_last, uop_red, err;
  logic [OP_W-1:0] uop_op;
  logic [IW-1:0] uop_rd, uop_rs1, uop_rs2;
  logic [EW_W-1:0] uop_ew;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vis_issue_seq #(.NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_fp_i(cfg_fp), .cfg_idx_i(cfg_idx), .cfg_vl_i(cfg_vl), .cfg_ew_i(cfg_ew),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op), .in_fp_i(in_fp),
    .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2), .in_pred_i(in_pred),
    .uop_valid_o(uop_valid), .uop_ready_i(uop_ready), .uop_op_o(uop_op), .uop_fp_o(uop_fp),
    .uop_rd_o(uop_rd), .uop_rs1_o(uop_rs1), .uop_rs2_o(uop_rs2), .uop_ew_o(uop_ew),
    .uop_en_o(uop_en), .uop_last_o(uop_last), .uop_red_o(uop_red), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit f, input int idx, input int vl, input int ew);
    @(negedge clk);
    cfg_we = 1; cfg_fp = f; cfg_idx = IW'(idx); cfg_vl = VL_W'(vl); cfg_ew = EW_W'(ew);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // issue one instruction and check the whole response; expectations follow the requirements
  task automatic run_instr(input string tag, input bit f, input int rd, input int ra, input int rb,
                           input logic [NREG-1:0] pr, input int n, input bit dv, input bit av,
                           input bit bv, input int ew, input bit xerr, input int stall);
    int lat;
    logic [OP_W-1:0] op;
    op = OP_W'(rd + ra);
    @(negedge clk);
    chk(in_ready == 1'b1, tag, "ready before issue", int'(in_ready), 1);
    in_valid = 1; in_fp = f; in_op = op;
    in_rd = IW'(rd); in_rs1 = IW'(ra); in_rs2 = IW'(rb); in_pred = pr;
    @(negedge clk);
    in_valid = 0; in_pred = '0;  // predicate must have been sampled at acceptance (R5)
    lat = 1;
    while (!uop_valid && !err && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 4, {tag, " R9"}, "latency", lat, 4);
    if (xerr) begin
      chk(err == 1'b1, tag, "err pulse", int'(err), 1);
      chk(uop_valid == 1'b0, tag, "no uop on error", int'(uop_valid), 0);
      @(negedge clk);
      chk(err == 1'b0 && in_ready == 1'b1, {tag, " R10"}, "err one cycle, ready", int'(err), 0);
      chk(uop_valid == 1'b0, tag, "no uop after error", int'(uop_valid), 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        if (i == 1 && stall > 0) begin
          uop_ready = 0;
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(uop_valid && int'(uop_rd) == rd + (dv ? 1 : 0), {tag, " R9"}, "held rd", int'(uop_rd), rd + (dv ? 1 : 0));
          end
          uop_ready = 1;
        end
        chk(uop_valid == 1'b1, tag, "uop valid", int'(uop_valid), 1);
        chk(int'(uop_rd) == rd + (dv ? i : 0), tag, "rd index", int'(uop_rd), rd + (dv ? i : 0));
        chk(int'(uop_rs1) == ra + (av ? i : 0), tag, "rs1 index", int'(uop_rs1), ra + (av ? i : 0));
        chk(int'(uop_rs2) == rb + (bv ? i : 0), tag, "rs2 index", int'(uop_rs2), rb + (bv ? i : 0));
        chk(int'(uop_ew) == ew, {tag, " R2"}, "width code", int'(uop_ew), ew);
        chk(uop_en == pr[i], {tag, " R5"}, "enable", int'(uop_en), int'(pr[i]));
        chk(uop_last == (i == n - 1), tag, "last flag", int'(uop_last), int'(i == n - 1));
        chk(uop_red == (!dv && n > 1), {tag, " R6"}, "reduction flag", int'(uop_red), int'(!dv && n > 1));
        chk(uop_op == op && uop_fp == f, tag, "op/file", int'(uop_op), int'(op));
        chk(in_ready == 1'b0, {tag, " R10"}, "busy during run", int'(in_ready), 0);
        @(negedge clk);
      end
      chk(uop_valid == 1'b0 && in_ready == 1'b1, {tag, " R10"}, "idle after run", int'(uop_valid), 0);
    end
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1 && uop_valid == 1'b0 && err == 1'b0, "R1", "reset outputs", int'(in_ready), 1);
    run_instr("R1", 0, 3, 4, 5, 32'h1, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    run_instr("R1", 1, 9, 9, 9, 32'h0, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_vector;
    cfg_write(0, 8, 4, 2);
    cfg_write(0, 12, 4, 1);
    cfg_write(0, 16, 4, 0);
    run_instr("R3", 0, 8, 12, 16, '1, 4, 1'b1, 1'b1, 1'b1, 2, 1'b0, 2);
  endtask

  task automatic t_scalar_vec;
    run_instr("R4", 0, 8, 12, 5, '1, 4, 1'b1, 1'b1, 1'b0, 2, 1'b0, 0);
    run_instr("R4", 0, 8, 7, 16, '1, 4, 1'b1, 1'b0, 1'b1, 2, 1'b0, 0);
  endtask

  task automatic t_pred;
    run_instr("R5", 0, 8, 12, 16, 32'h5, 4, 1'b1, 1'b1, 1'b1, 2, 1'b0, 0);
  endtask

  task automatic t_reduce;
    run_instr("R6", 0, 3, 12, 4, 32'hB, 4, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1);
  endtask

  task automatic t_file;
    cfg_write(1, 8, 2, 1);
    run_instr("R2", 1, 8, 8, 8, '1, 2, 1'b1, 1'b1, 1'b1, 1, 1'b0, 0);
    run_instr("R2", 0, 8, 12, 16, '1, 4, 1'b1, 1'b1, 1'b1, 2, 1'b0, 0);
  endtask

  task automatic t_illegal;
    cfg_write(0, 30, 4, 0);
    run_instr("R7", 0, 30, 30, 30, '1, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    cfg_write(0, 1, 0, 0);
    run_instr("R7", 0, 1, 2, 3, '1, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    cfg_write(0, 20, 2, 0);
    run_instr("R7", 0, 8, 20, 16, '1, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    run_instr("R7", 0, 2, 12, 20, '1, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    cfg_write(0, 28, 4, 3);
    run_instr("R7", 0, 28, 28, 28, '1, 4, 1'b1, 1'b1, 1'b1, 3, 1'b0, 0);
  endtask

  task automatic t_indep;
    cfg_write(0, 24, 3, 3);
    run_instr("R8", 0, 24, 24, 24, '1, 3, 1'b1, 1'b1, 1'b1, 3, 1'b0, 0);
    run_instr("R8", 0, 8, 12, 16, 32'h6, 4, 1'b1, 1'b1, 1'b1, 2, 1'b0, 0);
    run_instr("R8", 0, 2, 24, 5, '1, 3, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_scalar_vec();
    t_pred();
    t_reduce();
    t_file();
    t_illegal();
    t_indep();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule